// File: doc/BRIEF.md
# Fetch-Stage Direction and Target Predictor

This block predicts, in the fetch stage, whether the instruction at the current fetch address is a taken branch and where it goes. It holds two direct-mapped tables. The first holds one two-bit saturating counter per slot and predicts the direction. The second is a target buffer whose slots each hold a valid bit, an address tag and a target address. Fetch presents a PC and, in the same cycle, gets back three results: a target-buffer hit flag, a redirect flag and the next fetch address. The next fetch address is the stored target when the front end should redirect, and the sequential PC + 4 otherwise.

When a branch completes, the back end presents its PC, its real outcome and its real target on a resolve port that uses valid/ready. The port never applies back-pressure: ready is held high, and every cycle with valid high is one accepted update. In that same cycle the block compares what it would have predicted for that PC against the real result and raises a mispredict flag, so the pipeline can flush. At the next clock edge it trains the counter and, for a taken branch, writes the target-buffer slot. The counters only change direction after two wrong guesses in a row. Because of this, a loop branch costs one mispredict per loop exit instead of two.

Top module: `bp_predictor`

## Requirements
- R1: After reset, every counter holds 01 and every target-buffer slot is invalid. A lookup at any PC then returns hit 0, redirect 0 and next address PC + 4.
- R2: Counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken, and bit 1 gives the direction. A taken resolve moves the counter one step up and a not-taken resolve moves it one step down. The counter saturates at 11 and at 00.
- R3: From a strong state, one wrong outcome does not change the predicted direction. A second consecutive wrong outcome does.
- R4: Both tables are indexed by PC bits [IDX_W+1:2]. The tag is PC bits [PC_W-1:IDX_W+2]. A taken resolve writes the valid bit, the tag and the target into the indexed slot. A lookup hits only when the slot is valid and its tag matches, so a PC that shares an index but has a different tag misses.
- R5: The redirect flag is 1 only when the lookup hits and counter bit 1 is 1. In that case the next address is the stored target. Otherwise the next address is the PC + 4 fall-through.
- R6: In a cycle with rs_valid high, rs_mispredict is 1 when the predicted redirect (computed from the current table contents at rs_pc) differs from rs_taken. It is also 1 when both are taken but the stored target differs from rs_target. With rs_valid low it is 0.
- R7: A not-taken resolve leaves the target buffer unchanged.
- R8: When a lookup and a resolve address the same slot in the same cycle, the lookup returns the contents from before the update.
- R9: rs_ready is always 1. A cycle with rs_valid low changes no state, whatever the other resolve inputs carry.
- R10: A loop branch that is taken three times and then not taken, repeated, mispredicts once per loop exit after its first iteration has trained it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_hit | output | 1 | Target-buffer slot valid with matching tag |
| lk_taken | output | 1 | Redirect fetch to lk_target |
| lk_target | output | PC_W | Next fetch address (stored target or PC + 4) |
| rs_valid | input | 1 | Resolve record present |
| rs_ready | output | 1 | Resolve record accepted (always 1) |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome of the branch |
| rs_target | input | PC_W | Real target of the branch |
| rs_mispredict | output | 1 | Prediction for rs_pc was wrong; flush |

## Verification
The assertions take for granted that rs_valid and the resolve fields are stable for the whole cycle in which they are presented. They also assume that each accepted update reaches the table at the next rising edge with no stall. The bench changes every input only on falling edges and keeps rs_valid high for exactly one cycle per update, so each update is applied and checked one record at a time. The chosen PCs are word aligned and use distinct indices, except for one address that deliberately shares an index with a trained branch but carries a different tag, to test the tag compare.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t r;
    if (taken) r = (cur == CTR_ST) ? CTR_ST : cur + 2'd1;
    else       r = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output bp_pkg::ctr_t      rd_a_ctr,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output bp_pkg::ctr_t      rd_b_ctr,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_taken
);
  import bp_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  ctr_t cnt_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CTR_WNT;
    end else if (upd_en) begin
      cnt_q[upd_idx] <= ctr_step(cnt_q[upd_idx], upd_taken);
    end
  end

  assign rd_a_ctr = cnt_q[rd_a_idx];
  assign rd_b_ctr = cnt_q[rd_b_idx];

  AST_CTR_UP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken) |=> (cnt_q[$past(upd_idx)] >= $past(cnt_q[upd_idx]))); // R2
  AST_CTR_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken) |=> (cnt_q[$past(upd_idx)] <= $past(cnt_q[upd_idx]))); // R2
  AST_HYST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken && cnt_q[upd_idx] == CTR_ST) |=> cnt_q[$past(upd_idx)][1]); // R3
  AST_HYST_NOTTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken && cnt_q[upd_idx] == CTR_SNT) |=> !cnt_q[$past(upd_idx)][1]); // R3
endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  rd_a_pc,
  output logic             rd_a_hit,
  output logic [PC_W-1:0]  rd_a_tgt,
  input  logic [PC_W-1:0]  rd_b_pc,
  output logic             rd_b_hit,
  output logic [PC_W-1:0]  rd_b_tgt,
  input  logic             wr_en,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [PC_W-1:0]  wr_tgt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];

  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  assign wr_idx = wr_pc[IDX_W+1:2];
  assign wr_tag = wr_pc[PC_W-1:IDX_W+2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      tag_q[wr_idx]   <= wr_tag;
      tgt_q[wr_idx]   <= wr_tgt;
    end
  end

  logic [PC_W-1:0]  rd_pc  [2];
  logic             rd_hit [2];
  logic [PC_W-1:0]  rd_tgt [2];
  assign rd_pc[0] = rd_a_pc;
  assign rd_pc[1] = rd_b_pc;

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [IDX_W-1:0] idx;
    assign idx       = rd_pc[p][IDX_W+1:2];
    assign rd_hit[p] = valid_q[idx] && (tag_q[idx] == rd_pc[p][PC_W-1:IDX_W+2]);
    assign rd_tgt[p] = tgt_q[idx];
  end

  assign rd_a_hit = rd_hit[0];
  assign rd_a_tgt = rd_tgt[0];
  assign rd_b_hit = rd_hit[1];
  assign rd_b_tgt = rd_tgt[1];

  AST_FILL_ON_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
               && tgt_q[$past(wr_idx)] == $past(wr_tgt))); // R4
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(valid_q)); // R7
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target,
  input  logic            rs_valid,
  output logic            rs_ready,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  output logic            rs_mispredict
);
  import bp_pkg::*;

  ctr_t            lk_ctr, rs_ctr;
  logic            rs_hit;
  logic [PC_W-1:0] lk_stored, rs_stored;
  logic            rs_pred;

  bp_ctr_table #(.IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(lk_pc[IDX_W+1:2]), .rd_a_ctr(lk_ctr),
    .rd_b_idx(rs_pc[IDX_W+1:2]), .rd_b_ctr(rs_ctr),
    .upd_en(rs_valid), .upd_idx(rs_pc[IDX_W+1:2]), .upd_taken(rs_taken)
  );

  bp_target_buf #(.PC_W(PC_W), .IDX_W(IDX_W)) u_btb (
    .clk(clk), .rst_n(rst_n),
    .rd_a_pc(lk_pc), .rd_a_hit(lk_hit), .rd_a_tgt(lk_stored),
    .rd_b_pc(rs_pc), .rd_b_hit(rs_hit), .rd_b_tgt(rs_stored),
    .wr_en(rs_valid && rs_taken), .wr_pc(rs_pc), .wr_tgt(rs_target)
  );

  assign rs_ready  = 1'b1;
  assign lk_taken  = lk_hit && lk_ctr[1];
  assign lk_target = lk_taken ? lk_stored : lk_pc + PC_W'(4);

  assign rs_pred = rs_hit && rs_ctr[1];
  always_comb begin
    rs_mispredict = 1'b0;
    if (rs_valid) begin
      if (rs_pred != rs_taken)              rs_mispredict = 1'b1;
      else if (rs_taken && rs_stored != rs_target) rs_mispredict = 1'b1;
    end
  end
endmodule

// File: tb/tb_bp_predictor.sv
module tb_bp_predictor;
  localparam int PC_W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, rs_pc = '0, rs_target = '0;
  logic rs_valid = 1'b0, rs_taken = 1'b0;
  logic lk_hit, lk_taken, rs_ready, rs_mispredict;
  logic [PC_W-1:0] lk_target;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  bp_predictor #(.PC_W(PC_W), .IDX_W(4)) dut (.*);

  // bits: {taken, expected redirect before update, expected mispredict}
  localparam logic [2:0] LOOP_VEC [12] = '{
    3'b101, 3'b110, 3'b110, 3'b011,
    3'b110, 3'b110, 3'b110, 3'b011,
    3'b110, 3'b110, 3'b110, 3'b011};

  localparam logic [PC_W-1:0] PA = 32'h44, TA = 32'h20;
  localparam logic [PC_W-1:0] PB = 32'h108, TB = 32'h200;
  localparam logic [PC_W-1:0] PC_ = 32'h10C, PD = 32'h2108, PE = 32'h110;

  task automatic chk(input logic ok, input string req, input logic [PC_W-1:0] act,
                     input logic [PC_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a cycle at the falling edge, check lookup and mispredict, then clock.
  task automatic cyc(input logic [PC_W-1:0] lpc, input logic v, input logic [PC_W-1:0] rpc,
                     input logic t, input logic [PC_W-1:0] tgt,
                     input logic e_hit, input logic e_tk, input logic [PC_W-1:0] e_tgt,
                     input logic e_mp, input string req);
    @(negedge clk);
    lk_pc = lpc; rs_valid = v; rs_pc = rpc; rs_taken = t; rs_target = tgt;
    #1;
    chk(lk_hit == e_hit, {req, " hit"}, PC_W'(lk_hit), PC_W'(e_hit));
    chk(lk_taken == e_tk, {req, " taken"}, PC_W'(lk_taken), PC_W'(e_tk));
    chk(lk_target == e_tgt, {req, " target"}, lk_target, e_tgt);
    chk(rs_mispredict == e_mp, {req, " mispredict"}, PC_W'(rs_mispredict), PC_W'(e_mp));
    chk(rs_ready == 1'b1, "R9 ready", PC_W'(rs_ready), 1);
    @(posedge clk);
  endtask

  task automatic look(input logic [PC_W-1:0] lpc, input logic e_hit, input logic e_tk,
                      input logic [PC_W-1:0] e_tgt, input string req);
    cyc(lpc, 1'b0, '0, 1'b0, '0, e_hit, e_tk, e_tgt, 1'b0, req);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    look(PA, 0, 0, PA + 4, "R1 reset A");
    look(PB, 0, 0, PB + 4, "R1 reset B");

    // R10 nested loop: inner branch at PA, one mispredict per exit
    for (int i = 0; i < 12; i++) begin
      logic t, ep, em;
      {t, ep, em} = LOOP_VEC[i];
      cyc(PA, 1, PA, t, TA, (i != 0), ep, ep ? TA : PA + 4, em, "R10 loop");
    end

    // R2/R3 saturation and hysteresis at PB
    cyc(PB, 1, PB, 1, TB, 0, 0, PB + 4, 1, "R2 first taken");
    cyc(PB, 1, PB, 1, TB, 1, 1, TB, 0, "R2 weak taken");
    cyc(PB, 1, PB, 1, TB, 1, 1, TB, 0, "R2 strong taken");
    cyc(PB, 1, PB, 0, TB, 1, 1, TB, 1, "R3 first wrong");
    cyc(PB, 1, PB, 0, TB, 1, 1, TB, 1, "R3 still taken after one miss");
    cyc(PB, 1, PB, 0, TB, 1, 0, PB + 4, 0, "R3 flipped after two");
    cyc(PB, 1, PB, 0, TB, 1, 0, PB + 4, 0, "R2 down to 00");
    cyc(PB, 1, PB, 1, TB, 1, 0, PB + 4, 1, "R2 saturate 00");
    look(PB, 1, 0, PB + 4, "R2 one taken from 00 stays not-taken");

    // R4 alias: same index as PB, different tag
    look(PD, 0, 0, PD + 4, "R4 tag mismatch");

    // R7 not-taken resolve does not fill target buffer
    cyc(PC_, 1, PC_, 0, 32'h300, 0, 0, PC_ + 4, 0, "R7 nt resolve");
    look(PC_, 0, 0, PC_ + 4, "R7 no fill");

    // R9 idle resolve changes nothing
    cyc(PC_, 0, PC_, 1, 32'h300, 0, 0, PC_ + 4, 0, "R9 idle");
    look(PC_, 0, 0, PC_ + 4, "R9 no update");

    // R8 same-cycle lookup sees old contents
    cyc(PE, 1, PE, 1, 32'h400, 0, 0, PE + 4, 1, "R8 same cycle");
    look(PE, 1, 1, 32'h400, "R8 next cycle");

    // R6 wrong stored target, R5 redirect to new target
    cyc(PA, 1, PA, 1, 32'h80, 1, 1, TA, 1, "R6 target mismatch");
    look(PA, 1, 1, 32'h80, "R5 redirect new target");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule